// File: doc/BRIEF.md
# Event-Triggered Single-Item Transfer Controller

This block moves one data item between two memory locations each time a peripheral raises a request. A full interrupt routine is not run. Eight channels are available. Each channel holds a source pointer, a destination pointer, a transfer counter and a control word. Requests are latched as pending. The lowest-numbered pending channel is granted. The engine then spends one bus service, a read cycle followed by a write cycle, moving a byte or a word. After the move it advances one of the two pointers and, unless the channel runs continuously, decrements the counter.

A channel that is disabled, or whose counter has reached zero outside continuous mode, does not touch the bus when its request is granted. The request is instead forwarded as a one-cycle pulse on that channel's standard interrupt line. This lets software take over once a block of data is complete.

Channel registers are written and read back through a small register port. A write in progress holds off new grants.

Top module: `evt_xfer_ctrl`

## Requirements
- R1: After reset, `busy_o`, `mem_req` and `irq_o` are low, and every channel field reads back as zero.
- R2: A write with `cfg_we` high stores `cfg_wdata` into the field of channel `cfg_ch` chosen by `cfg_sel`. The codes are 0 = source pointer, 1 = destination pointer, 2 = counter (low CW bits) and 3 = control (low 4 bits). `cfg_rdata` combinationally returns the addressed field, zero-extended.
- R3: A serviceable grant produces exactly two bus cycles, with `busy_o` high during both. The first is a read at the source pointer. The second is a write at the destination pointer that carries the data returned by the read.
- R4: Control bit 1 selects the item size: 0 = byte, 1 = word. A byte service writes only the low 8 bits of the read data and advances the chosen pointer by 1. A word service moves 16 bits and advances the chosen pointer by 2.
- R5: Control bit 2 selects which pointer advances: 0 = source, 1 = destination. The other pointer is left unchanged.
- R6: Control bit 3 selects continuous mode. When it is clear, each service decrements the counter by one. When it is set, the counter is left unchanged.
- R7: A granted request on a channel whose enable (control bit 0) is clear, or whose counter is zero with continuous mode clear, makes no bus access. It pulses that channel's `irq_o` bit for one cycle and leaves all channel fields unchanged.
- R8: When several channels are pending, the lowest-numbered channel is granted first. The others stay pending and are served afterwards in ascending order.
- R9: No grant is made in a cycle where `cfg_we` is high. A pending request waits until the write phase ends.
- R10: Pointer arithmetic wraps modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_i | input | NCH | Per-channel request pulses |
| cfg_we | input | 1 | Register port write strobe |
| cfg_ch | input | clog2(NCH) | Register port channel index |
| cfg_sel | input | 2 | Register port field code |
| cfg_wdata | input | AW | Register port write data |
| cfg_rdata | output | AW | Register port read data |
| mem_req | output | 1 | Bus cycle active |
| mem_we | output | 1 | Bus cycle is a write |
| mem_word | output | 1 | Bus cycle size, 1 = word |
| mem_addr | output | AW | Bus byte address |
| mem_wdata | output | 16 | Bus write data |
| mem_rdata | input | 16 | Bus read data, valid the cycle after a read |
| irq_o | output | NCH | Forwarded standard interrupt pulses |
| busy_o | output | 1 | Transfer in progress |

## Verification
The bench builds the block with eight channels, an 8-bit address and a 4-bit counter. The small address puts pointer wrap-around a single word service away from 0xFF. The short counter lets random request bursts exhaust channels often, which exercises the fall-back to forwarded interrupts. Random configurations of size, pointer choice and continuous mode are mixed with directed cases for simultaneous requests, disabled channels and grants held off by register writes.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int DATA_W = 16;
  localparam int CTL_W  = 4;

  // control field bit positions
  localparam int CTL_EN     = 0;
  localparam int CTL_WORD   = 1;
  localparam int CTL_DSTINC = 2;
  localparam int CTL_CONT   = 3;

  // register port field codes
  localparam logic [1:0] SEL_SRC = 2'd0;
  localparam logic [1:0] SEL_DST = 2'd1;
  localparam logic [1:0] SEL_CNT = 2'd2;
  localparam logic [1:0] SEL_CTL = 2'd3;

  typedef enum logic [1:0] {ENG_IDLE, ENG_RD, ENG_WR} eng_state_e;

  // pointer advance for one item
  function automatic logic [1:0] item_step(input logic word);
    return word ? 2'd2 : 2'd1;
  endfunction

  // can a channel with this control/count move data now
  function automatic logic can_move(input logic [CTL_W-1:0] ctl, input logic cnt_zero);
    return ctl[CTL_EN] && (ctl[CTL_CONT] || !cnt_zero);
  endfunction
endpackage

// File: rtl/xfer_pick.sv
module xfer_pick #(
  parameter int NCH = 8,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0]  pend,
  output logic            any,
  output logic [CH_W-1:0] idx
);
  always_comb begin
    any = |pend;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend[i]) idx = CH_W'(i);
    end
  end
endmodule

// File: rtl/xfer_chan_regs.sv
module xfer_chan_regs import xfer_pkg::*; #(
  parameter int NCH = 8,
  parameter int AW  = 16,
  parameter int CW  = 8,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CH_W-1:0]  cfg_ch,
  input  logic [1:0]       cfg_sel,
  input  logic [AW-1:0]    cfg_wdata,
  output logic [AW-1:0]    cfg_rdata,
  input  logic             upd_evt,
  input  logic [CH_W-1:0]  eng_ch,
  output logic [AW-1:0]    cur_src,
  output logic [AW-1:0]    cur_dst,
  output logic [CW-1:0]    cur_cnt,
  output logic [CTL_W-1:0] cur_ctl,
  output logic [NCH-1:0]   svc_ok
);
  logic [AW-1:0]    src_q [NCH];
  logic [AW-1:0]    dst_q [NCH];
  logic [CW-1:0]    cnt_q [NCH];
  logic [CTL_W-1:0] ctl_q [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic hit, wsel;
    logic [AW-1:0] step;
    assign hit  = upd_evt && (eng_ch == CH_W'(g));
    assign wsel = cfg_we && (cfg_ch == CH_W'(g));
    assign step = AW'(item_step(ctl_q[g][CTL_WORD]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_q[g] <= '0;
        dst_q[g] <= '0;
        cnt_q[g] <= '0;
        ctl_q[g] <= '0;
      end else begin
        if (hit) begin
          if (ctl_q[g][CTL_DSTINC]) dst_q[g] <= dst_q[g] + step;
          else                      src_q[g] <= src_q[g] + step;
          if (!ctl_q[g][CTL_CONT])  cnt_q[g] <= cnt_q[g] - 1'b1;
        end
        if (wsel) begin
          case (cfg_sel)
            SEL_SRC: src_q[g] <= cfg_wdata;
            SEL_DST: dst_q[g] <= cfg_wdata;
            SEL_CNT: cnt_q[g] <= cfg_wdata[CW-1:0];
            default: ctl_q[g] <= cfg_wdata[CTL_W-1:0];
          endcase
        end
      end
    end

    assign svc_ok[g] = can_move(ctl_q[g], cnt_q[g] == '0);
  end

  assign cur_src = src_q[eng_ch];
  assign cur_dst = dst_q[eng_ch];
  assign cur_cnt = cnt_q[eng_ch];
  assign cur_ctl = ctl_q[eng_ch];

  always_comb begin
    case (cfg_sel)
      SEL_SRC: cfg_rdata = src_q[cfg_ch];
      SEL_DST: cfg_rdata = dst_q[cfg_ch];
      SEL_CNT: cfg_rdata = AW'(cnt_q[cfg_ch]);
      default: cfg_rdata = AW'(ctl_q[cfg_ch]);
    endcase
  end

  // R6: the engine never finishes a move on an exhausted, non-continuous channel
  assert_live_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |-> (cur_ctl[CTL_CONT] || cur_cnt != '0));

  // R5: a completed move shifts exactly one of the two pointers
  assert_one_ptr_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && !cfg_we) |=> ((cur_src != $past(cur_src)) != (cur_dst != $past(cur_dst))));
endmodule

// File: rtl/xfer_engine.sv
module xfer_engine import xfer_pkg::*; #(
  parameter int NCH = 8,
  parameter int AW  = 16,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    req_i,
  input  logic              cfg_we,
  input  logic [NCH-1:0]    svc_ok,
  input  logic [AW-1:0]     cur_src,
  input  logic [AW-1:0]     cur_dst,
  input  logic [CTL_W-1:0]  cur_ctl,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_word,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [NCH-1:0]    irq_o,
  output logic              busy_o,
  output logic [CH_W-1:0]   eng_ch,
  output logic              done_evt
);
  eng_state_e      st_q;
  logic [NCH-1:0]  pend_q, clr_vec, irq_q;
  logic [CH_W-1:0] cur_q, pick_idx;
  logic            pick_any, grant_evt;

  xfer_pick #(.NCH(NCH)) u_pick (
    .pend (pend_q),
    .any  (pick_any),
    .idx  (pick_idx)
  );

  assign grant_evt = (st_q == ENG_IDLE) && pick_any && !cfg_we;
  assign clr_vec   = grant_evt ? (NCH'(1) << pick_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ENG_IDLE;
      pend_q <= '0;
      irq_q  <= '0;
      cur_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_vec) | req_i;
      irq_q  <= '0;
      case (st_q)
        ENG_IDLE: if (grant_evt) begin
          if (svc_ok[pick_idx]) begin
            st_q  <= ENG_RD;
            cur_q <= pick_idx;
          end else begin
            irq_q <= clr_vec;
          end
        end
        ENG_RD:  st_q <= ENG_WR;
        default: st_q <= ENG_IDLE;
      endcase
    end
  end

  assign eng_ch    = cur_q;
  assign done_evt  = (st_q == ENG_WR);
  assign busy_o    = (st_q != ENG_IDLE);
  assign mem_req   = busy_o;
  assign mem_we    = done_evt;
  assign mem_word  = cur_ctl[CTL_WORD];
  assign mem_addr  = (st_q == ENG_RD) ? cur_src : cur_dst;
  assign mem_wdata = mem_word ? mem_rdata : {8'h00, mem_rdata[7:0]};
  assign irq_o     = irq_q;

  // R3: every read cycle is followed at once by its write cycle
  assert_rd_then_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> (mem_req && mem_we));

  // R7: forwarded interrupts come one channel at a time
  assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_o));

  // R7: a forwarded interrupt never coincides with bus activity
  assert_irq_quiet_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_o) |-> !mem_req);

  // R9: an idle engine stays idle across a register write cycle
  assert_hold_on_cfg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !busy_o) |=> !busy_o);
endmodule

// File: rtl/evt_xfer_ctrl.sv
module evt_xfer_ctrl import xfer_pkg::*; #(
  parameter int NCH = 8,
  parameter int AW  = 16,
  parameter int CW  = 8,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    req_i,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [1:0]        cfg_sel,
  input  logic [AW-1:0]     cfg_wdata,
  output logic [AW-1:0]     cfg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_word,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [NCH-1:0]    irq_o,
  output logic              busy_o
);
  logic [NCH-1:0]   svc_ok;
  logic [AW-1:0]    cur_src, cur_dst;
  logic [CW-1:0]    cur_cnt;
  logic [CTL_W-1:0] cur_ctl;
  logic [CH_W-1:0]  eng_ch;
  logic             done_evt;

  xfer_chan_regs #(.NCH(NCH), .AW(AW), .CW(CW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_ch    (cfg_ch),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .upd_evt   (done_evt),
    .eng_ch    (eng_ch),
    .cur_src   (cur_src),
    .cur_dst   (cur_dst),
    .cur_cnt   (cur_cnt),
    .cur_ctl   (cur_ctl),
    .svc_ok    (svc_ok)
  );

  xfer_engine #(.NCH(NCH), .AW(AW)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .cfg_we    (cfg_we),
    .svc_ok    (svc_ok),
    .cur_src   (cur_src),
    .cur_dst   (cur_dst),
    .cur_ctl   (cur_ctl),
    .mem_rdata (mem_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_word  (mem_word),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .irq_o     (irq_o),
    .busy_o    (busy_o),
    .eng_ch    (eng_ch),
    .done_evt  (done_evt)
  );
endmodule

// File: tb/evt_xfer_ctrl_bench.sv
module evt_xfer_ctrl_bench;
  localparam int NCH = 8;
  localparam int AW  = 8;
  localparam int CW  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] req_i = '0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_ch = '0;
  logic [1:0] cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic [AW-1:0] cfg_rdata;
  logic mem_req, mem_we, mem_word;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic [NCH-1:0] irq_o;
  logic busy_o;

  always #10 clk = ~clk;

  evt_xfer_ctrl #(.NCH(NCH), .AW(AW), .CW(CW)) u_evt_xfer_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req_i),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .irq_o(irq_o), .busy_o(busy_o)
  );

  // memory seen by the block, and the bench's expected copy
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata[7:0];
        if (mem_word) mem[mem_addr + 8'd1] <= mem_wdata[15:8];
      end else begin
        mem_rdata <= {mem[mem_addr + 8'd1], mem[mem_addr]};
      end
    end
  end

  // monitors sample between edges
  int bus_cycles = 0;
  int irq_seen [NCH];
  logic [7:0] wlog [512];
  int wn = 0;
  always @(negedge clk) begin
    if (mem_req) bus_cycles++;
    if (mem_req && mem_we && wn < 512) begin wlog[wn] = mem_addr; wn++; end
    for (int i = 0; i < NCH; i++) if (irq_o[i]) irq_seen[i]++;
  end

  // shadow channel state
  logic [7:0] m_src [NCH];
  logic [7:0] m_dst [NCH];
  logic [3:0] m_cnt [NCH];
  logic [3:0] m_ctl [NCH];
  int exp_irq [NCH];
  int exp_bus = 0;

  int total = 0;
  int bad = 0;
  bit done_flag = 0;

  task automatic check(input string tag, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] step_for(input logic [3:0] ctl);
    return ctl[1] ? 8'd2 : 8'd1;
  endfunction

  function automatic bit may_move(input int ch);
    return m_ctl[ch][0] && (m_ctl[ch][3] || m_cnt[ch] != 4'd0);
  endfunction

  // expected effect of one granted request
  function automatic void model_serve(input int ch);
    logic [7:0] lo, hi;
    if (!may_move(ch)) begin
      exp_irq[ch]++;
      return;
    end
    lo = exp_mem[m_src[ch]];
    hi = exp_mem[m_src[ch] + 8'd1];
    exp_mem[m_dst[ch]] = lo;
    if (m_ctl[ch][1]) exp_mem[m_dst[ch] + 8'd1] = hi;
    if (m_ctl[ch][2]) m_dst[ch] = m_dst[ch] + step_for(m_ctl[ch]);
    else              m_src[ch] = m_src[ch] + step_for(m_ctl[ch]);
    if (!m_ctl[ch][3]) m_cnt[ch] = m_cnt[ch] - 4'd1;
    exp_bus += 2;
  endfunction

  task automatic wr_cfg(input int ch, input int sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_sel = 2'(sel); cfg_wdata = 8'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_cfg(input int ch, input int sel, output int val);
    cfg_ch = 3'(ch); cfg_sel = 2'(sel);
    #1 val = int'(cfg_rdata);
  endtask

  task automatic setup(input int ch, input int src, input int dst, input int cnt, input int ctl);
    wr_cfg(ch, 0, src); wr_cfg(ch, 1, dst); wr_cfg(ch, 2, cnt); wr_cfg(ch, 3, ctl);
    m_src[ch] = 8'(src); m_dst[ch] = 8'(dst); m_cnt[ch] = 4'(cnt); m_ctl[ch] = 4'(ctl);
  endtask

  task automatic fire(input logic [NCH-1:0] mask);
    @(negedge clk); req_i = mask;
    @(negedge clk); req_i = '0;
    repeat (10) @(negedge clk);
  endtask

  function automatic int mem_diffs();
    int n = 0;
    for (int a = 0; a < 256; a++) if (mem[a] !== exp_mem[a]) n++;
    return n;
  endfunction

  task automatic check_chan(input string tag, input int ch);
    int v;
    @(negedge clk);
    rd_cfg(ch, 0, v); check({tag, " src"}, v, int'(m_src[ch]));
    rd_cfg(ch, 1, v); check({tag, " dst"}, v, int'(m_dst[ch]));
    rd_cfg(ch, 2, v); check({tag, " cnt"}, v, int'(m_cnt[ch]));
    check({tag, " irq"}, irq_seen[ch], exp_irq[ch]);
    check({tag, " bus cycles"}, bus_cycles, exp_bus);
    check({tag, " memory"}, mem_diffs(), 0);
  endtask

  initial begin
    int v, s, b0, seed;
    seed = $urandom(32'd9173);
    for (int a = 0; a < 256; a++) begin
      mem[a] = 8'($urandom);
      exp_mem[a] = mem[a];
    end
    for (int i = 0; i < NCH; i++) begin
      irq_seen[i] = 0; exp_irq[i] = 0;
      m_src[i] = '0; m_dst[i] = '0; m_cnt[i] = '0; m_ctl[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 busy", int'(busy_o), 0);
    check("R1 mem_req", int'(mem_req), 0);
    check("R1 irq", int'(irq_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int sl = 0; sl < 4; sl++) begin
      rd_cfg(3, sl, v); check("R1 field zero", v, 0);
    end

    // R2: register port write/readback
    setup(4, 8'h12, 8'h34, 5, 4'b0110);
    rd_cfg(4, 0, v); check("R2 src", v, 8'h12);
    rd_cfg(4, 1, v); check("R2 dst", v, 8'h34);
    rd_cfg(4, 2, v); check("R2 cnt", v, 5);
    rd_cfg(4, 3, v); check("R2 ctl", v, 4'b0110);

    // R3 R4 R5: byte move, source pointer advances
    setup(1, 8'h10, 8'h80, 3, 4'b0001);
    fire(8'h02); model_serve(1);
    check_chan("R3 R4 byte", 1);
    // R4 R5: word move, destination pointer advances
    setup(1, 8'h20, 8'h90, 3, 4'b0111);
    fire(8'h02); model_serve(1);
    check_chan("R4 R5 word dst", 1);

    // R6: continuous mode keeps the counter
    setup(0, 8'h30, 8'hA0, 2, 4'b1011);
    fire(8'h01); model_serve(0);
    fire(8'h01); model_serve(0);
    check_chan("R6 continuous", 0);

    // R6 R7: counter runs out, then interrupt forwarded
    setup(3, 8'h40, 8'hB0, 1, 4'b0001);
    fire(8'h08); model_serve(3);
    check_chan("R6 decrement", 3);
    fire(8'h08); model_serve(3);
    check_chan("R7 exhausted", 3);

    // R7: disabled channel forwards
    setup(6, 8'h50, 8'hC0, 4, 4'b0000);
    fire(8'h40); model_serve(6);
    check_chan("R7 disabled", 6);

    // R10: pointer wrap
    setup(2, 8'hFF, 8'hD0, 2, 4'b0011);
    fire(8'h04); model_serve(2);
    check_chan("R10 wrap", 2);

    // R8: simultaneous requests, lowest first
    setup(2, 8'h00, 8'h40, 3, 4'b0001);
    setup(5, 8'h08, 8'h50, 3, 4'b0001);
    setup(6, 8'h0C, 8'h60, 3, 4'b0001);
    b0 = wn;
    fire(8'h64); model_serve(2); model_serve(5); model_serve(6);
    check("R8 first", int'(wlog[b0]), 8'h40);
    check("R8 second", int'(wlog[b0 + 1]), 8'h50);
    check("R8 third", int'(wlog[b0 + 2]), 8'h60);
    check_chan("R8 ch6", 6);

    // R9: no grant while the register port writes
    setup(0, 8'h70, 8'hE0, 2, 4'b0001);
    b0 = bus_cycles;
    @(negedge clk);
    req_i = 8'h01; cfg_we = 1'b1; cfg_ch = 3'd7; cfg_sel = 2'd3; cfg_wdata = 8'h00;
    @(negedge clk); req_i = '0;
    repeat (3) @(negedge clk);
    check("R9 held off", bus_cycles - b0, 0);
    cfg_we = 1'b0; m_ctl[7] = 4'h0;
    repeat (10) @(negedge clk);
    model_serve(0);
    check_chan("R9 released", 0);

    // random mix
    for (int it = 0; it < 40; it++) begin
      int ch, ctl, n;
      ch  = $urandom_range(0, NCH - 1);
      ctl = ($urandom_range(0, 5) != 0 ? 1 : 0) | ($urandom_range(0, 7) << 1);
      setup(ch, $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 3), ctl);
      n = $urandom_range(1, 3);
      for (int k = 0; k < n; k++) begin
        fire(NCH'(1) << ch); model_serve(ch);
      end
      check_chan("R3 R4 R5 R6 R7 random", ch);
    end
    s = 0;
    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule